// File: doc/BRIEF.md
# Keyed-Switch Sampling ADC Controller

This block sits between a simple register bus and an external analog-to-digital converter core that measures a touch-panel style set of inputs. Software picks the analog input by loading a switch code into a guarded register. A read of the result register returns the current result word and also requests a fresh conversion, so software polls by reading the result repeatedly until the ready flag in bit 31 is set.

The block enforces the analog timing itself. After every switch change it waits a settling interval before starting a conversion, and it keeps starts spaced by at least the minimum conversion period. Both intervals are counted in module clock cycles. They are derived from the clock frequency parameter and the selected divisor, which is either 4 (fast) or 16 (slow). Writes to the switch register are accepted only after a one-shot key. Refused attempts leave a sticky error flag that software can read.

Top module: `adc_lockgate_ctrl`

## Requirements
- R1: After synchronous reset the result word, switch code, divisor select and error flag all read zero, `conv_req` is low, and no key is armed.
- R2: A bus read at offset 0x08 returns the result word as it stands in that cycle, and bit 31 reads 0 on every later read until a new conversion completes.
- R3: A completed conversion sets bit 31 and places the converter's 16-bit two's-complement value in bits 15:0, with bits 30:16 zero.
- R4: Writing 0x000000AA to offset 0x20 arms a key. The next bus access, if it is a write to offset 0x18, loads bits 11:0 into the switch code and disarms the key. Idle cycles between the two do not disarm.
- R5: A write to offset 0x18 without an armed key leaves the switch code unchanged and sets an error flag. The flag reads as bit 0 at offset 0x20 and is cleared by that read.
- R6: Any other bus access while the key is armed disarms it. This includes reads, writes elsewhere and lock writes of any value other than 0x000000AA. A lock write of 0x000000AA re-arms the key.
- R7: Two rising edges of `conv_req` are never closer than the conversion period: ceil(CLK_HZ/3750) cycles with the fast divisor, ceil(CLK_HZ/925) with the slow one. A request raised earlier is held back until the period expires.
- R8: After a switch update at edge s, no conversion starts before edge s+ceil(CLK_HZ/2000) with the fast divisor, or s+ceil(CLK_HZ/500) with the slow one. A pending request starts exactly at that edge if the conversion period has also expired.
- R9: Bit 0 at offset 0x10 selects the divisor: 1 for fast, 0 for slow. The value in force when a timer is loaded sets that timer's interval.
- R10: A result read or switch update made while a conversion is in flight discards that conversion. Bit 31 stays clear until a later conversion completes.
- R11: `conv_req` stays high until `conv_ack` is sampled high. The result is captured from `conv_data` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| sw_code | output | SW_W | Analog switch code driven to the input multiplexer |
| conv_req | output | 1 | Conversion request to the converter core |
| conv_ack | input | 1 | Converter core has a sample on `conv_data` |
| conv_data | input | 16 | Converted sample, two's complement |

## Verification
The embedded assertions check the following on every cycle:
- the switch code changes only when a key was armed;
- a start happens only after both the settling timer and the spacing timer have run out;
- the request is held through a missing acknowledge;
- the ready flag clears after any result read and rises only on an accepted handshake;
- the error flag is sticky, and any access disarms the key.

Only the bench's scenarios can show the exact cycle counts of settling and spacing under each divisor, the discard of an in-flight conversion, and the sequences of key, intervening access and switch write that decide whether a write is accepted.

// File: rtl/adc_lg_pkg.sv
package adc_lg_pkg;

    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned SAMPLE_W = 16;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

    localparam logic [ADDR_W-1:0] OFF_RESULT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIVSEL = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SWITCH = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_LOCK   = 8'h20;

    // Rates in events per second used to derive cycle counts.
    localparam int unsigned CONV_RATE_FAST   = 3750;
    localparam int unsigned CONV_RATE_SLOW   = 925;
    localparam int unsigned SETTLE_RATE_FAST = 2000; // 500 us
    localparam int unsigned SETTLE_RATE_SLOW = 500;  // 2 ms

    typedef enum logic [2:0] {
        REG_NONE,
        REG_RESULT,
        REG_DIVSEL,
        REG_SWITCH,
        REG_LOCK
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        reg_sel_e         target;
        logic [BUS_W-1:0] wdata;
    } bus_op_t;

    typedef struct packed {
        logic                ready;
        logic [SAMPLE_W-1:0] value;
    } result_t;

    function automatic int unsigned cycles_for(input int unsigned hz, input int unsigned rate);
        int unsigned c;
        c = (hz + rate - 1) / rate;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] addr);
        case (addr)
            OFF_RESULT: return REG_RESULT;
            OFF_DIVSEL: return REG_DIVSEL;
            OFF_SWITCH: return REG_SWITCH;
            OFF_LOCK:   return REG_LOCK;
            default:    return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/adc_lg_countdown.sv
module adc_lg_countdown #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/adc_lg_keygate.sv
module adc_lg_keygate
    import adc_lg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    output logic    sw_we,
    output logic    armed,
    output logic    err
);
    logic armed_q, err_q;
    logic key_write, sw_attempt, lock_read;

    assign key_write  = op.valid && op.write && (op.target == REG_LOCK) && (op.wdata == UNLOCK_KEY);
    assign sw_attempt = op.valid && op.write && (op.target == REG_SWITCH);
    assign lock_read  = op.valid && !op.write && (op.target == REG_LOCK);
    assign sw_we      = sw_attempt && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (op.valid) armed_q <= key_write;
            if (sw_attempt && !armed_q) err_q <= 1'b1;
            else if (lock_read)         err_q <= 1'b0;
        end
    end

    assign armed = armed_q;
    assign err   = err_q;

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (err_q && !lock_read) |=> err_q);

    assert_any_access_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        (op.valid && !(op.write && op.target == REG_LOCK && op.wdata == UNLOCK_KEY)) |=> !armed_q);
endmodule

// File: rtl/adc_lg_convseq.sv
module adc_lg_convseq
    import adc_lg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_rd,
    input  logic                discard,
    input  logic                gap_idle,
    input  logic                settle_idle,
    input  logic                conv_ack,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                conv_req,
    output logic                start_fire,
    output result_t             result
);
    logic    pend_q, req_q, stale_q;
    result_t res_q;
    logic    done, keep, drop_evt;

    assign start_fire = pend_q && !req_q && gap_idle && settle_idle;
    assign done       = req_q && conv_ack;
    assign drop_evt   = start_rd || discard;
    assign keep       = done && !stale_q && !drop_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            req_q   <= 1'b0;
            stale_q <= 1'b0;
            res_q   <= '0;
        end else begin
            if (start_rd)        pend_q <= 1'b1;
            else if (start_fire) pend_q <= 1'b0;

            if (start_fire)  req_q <= 1'b1;
            else if (done)   req_q <= 1'b0;

            if (drop_evt && ((req_q && !conv_ack) || start_fire)) stale_q <= 1'b1;
            else if (done)                                         stale_q <= 1'b0;

            if (start_rd) begin
                res_q.ready <= 1'b0;
            end else if (keep) begin
                res_q.ready <= 1'b1;
                res_q.value <= conv_data;
            end
        end
    end

    assign conv_req = req_q;
    assign result   = res_q;

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (req_q && !conv_ack) |=> req_q);

    assert_ready_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        start_rd |=> !res_q.ready);

    assert_ready_from_handshake_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(res_q.ready) |-> $past(req_q && conv_ack));
endmodule

// File: rtl/adc_lockgate_ctrl.sv
module adc_lockgate_ctrl
    import adc_lg_pkg::*;
#(
    parameter int unsigned CLK_HZ = 14745600,
    parameter int unsigned SW_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic [SW_W-1:0]     sw_code,
    output logic                conv_req,
    input  logic                conv_ack,
    input  logic [SAMPLE_W-1:0] conv_data
);
    localparam int unsigned CONV_FAST   = cycles_for(CLK_HZ, CONV_RATE_FAST);
    localparam int unsigned CONV_SLOW   = cycles_for(CLK_HZ, CONV_RATE_SLOW);
    localparam int unsigned SETTLE_FAST = cycles_for(CLK_HZ, SETTLE_RATE_FAST);
    localparam int unsigned SETTLE_SLOW = cycles_for(CLK_HZ, SETTLE_RATE_SLOW);
    localparam int unsigned MAX_CYC     = (SETTLE_SLOW > CONV_SLOW) ? SETTLE_SLOW : CONV_SLOW;
    localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);
    localparam int unsigned N_TIMERS    = 2;
    localparam int unsigned T_GAP       = 0;
    localparam int unsigned T_SETTLE    = 1;

    bus_op_t         op;
    logic            sw_we, key_armed, key_err;
    logic            rd_result;
    logic [SW_W-1:0] switch_q;
    logic            div_fast_q;
    logic            start_fire;
    result_t         result;

    logic [N_TIMERS-1:0] t_load, t_idle;
    logic [CNT_W-1:0]    t_val [N_TIMERS];

    assign op.valid  = bus_sel;
    assign op.write  = bus_wr;
    assign op.target = decode_offset(bus_addr);
    assign op.wdata  = bus_wdata;

    assign rd_result = op.valid && !op.write && (op.target == REG_RESULT);

    adc_lg_keygate u_keygate (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .sw_we (sw_we),
        .armed (key_armed),
        .err   (key_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            switch_q   <= '0;
            div_fast_q <= 1'b0;
        end else begin
            if (sw_we) switch_q <= op.wdata[SW_W-1:0];
            if (op.valid && op.write && op.target == REG_DIVSEL) div_fast_q <= op.wdata[0];
        end
    end

    assign t_load[T_GAP]    = start_fire;
    assign t_val[T_GAP]     = div_fast_q ? CNT_W'(CONV_FAST - 1) : CNT_W'(CONV_SLOW - 1);
    assign t_load[T_SETTLE] = sw_we;
    assign t_val[T_SETTLE]  = div_fast_q ? CNT_W'(SETTLE_FAST - 1) : CNT_W'(SETTLE_SLOW - 1);

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
        adc_lg_countdown #(.CNT_W(CNT_W)) u_cd (
            .clk      (clk),
            .rst      (rst),
            .load     (t_load[g]),
            .load_val (t_val[g]),
            .idle     (t_idle[g])
        );
    end

    adc_lg_convseq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_rd    (rd_result),
        .discard     (sw_we),
        .gap_idle    (t_idle[T_GAP]),
        .settle_idle (t_idle[T_SETTLE]),
        .conv_ack    (conv_ack),
        .conv_data   (conv_data),
        .conv_req    (conv_req),
        .start_fire  (start_fire),
        .result      (result)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.valid && !op.write) begin
            case (op.target)
                REG_RESULT: bus_rdata = {result.ready, {(BUS_W-1-SAMPLE_W){1'b0}}, result.value};
                REG_DIVSEL: bus_rdata = {{(BUS_W-1){1'b0}}, div_fast_q};
                REG_SWITCH: bus_rdata = {{(BUS_W-SW_W){1'b0}}, switch_q};
                REG_LOCK:   bus_rdata = {{(BUS_W-1){1'b0}}, key_err};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign sw_code = switch_q;

    assert_switch_guarded_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(switch_q) |-> $past(key_armed));

    assert_start_after_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req) |-> $past(t_idle[T_GAP]));

    assert_start_after_settle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req) |-> $past(t_idle[T_SETTLE]));
endmodule

// File: tb/adc_lockgate_ctrl_test.sv
`timescale 1ns/100ps
module adc_lockgate_ctrl_test;
    localparam int unsigned HZ     = 37000;
    localparam int unsigned CONV_F = 10;
    localparam int unsigned CONV_S = 40;
    localparam int unsigned SET_F  = 19;
    localparam int unsigned SET_S  = 74;
    localparam logic [7:0] A_RES = 8'h08, A_DIV = 8'h10, A_SW = 8'h18, A_LCK = 8'h20;

    // {divisor fast, switch code[11:0], sample[15:0]}
    localparam logic [28:0] VEC [6] = '{
        {1'b0, 12'h608, 16'h61A8},
        {1'b1, 12'h680, 16'h9E58},
        {1'b1, 12'h640, 16'h0000},
        {1'b0, 12'h620, 16'h1234},
        {1'b1, 12'h610, 16'hFFFF},
        {1'b0, 12'h601, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] sw_code;
    logic        conv_req;
    logic        conv_ack;
    logic [15:0] conv_data = '0;
    logic        hold = 1'b0;

    int tests = 0, fails = 0;
    int cyc = 0, rise_cnt = 0, last_rise = 0, prev_rise = 0, wr_edge = 0;
    logic req_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_lockgate_ctrl #(.CLK_HZ(HZ), .SW_W(12)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_code(sw_code),
        .conv_req(conv_req), .conv_ack(conv_ack), .conv_data(conv_data)
    );

    // Converter stub: acknowledges one cycle after seeing a request.
    always @(posedge clk) begin
        if (rst) conv_ack <= 1'b0;
        else     conv_ack <= conv_req && !conv_ack && !hold;
    end

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (conv_req && !req_prev) begin
            rise_cnt  = rise_cnt + 1;
            prev_rise = last_rise;
            last_rise = cyc;
        end
        req_prev = conv_req;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        wr_edge = cyc + 1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rises(input int target);
        int k = 0;
        while (rise_cnt < target && k < 400) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        logic [31:0] x;
        int s, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(sw_code == 12'h000 && !conv_req, "R1 outputs", {19'b0, conv_req, sw_code}, 32'h0);
        rd(A_RES, x);  check(x == 32'h0, "R1 result", x, 32'h0);
        rd(A_SW, x);   check(x == 32'h0, "R1 switch", x, 32'h0);
        rd(A_DIV, x);  check(x == 32'h0, "R1 divisor slow", x, 32'h0);
        rd(A_LCK, x);  check(x == 32'h0, "R1 error", x, 32'h0);
        idle(60);

        // R5: unkeyed write refused, sticky error cleared by read
        wr(A_SW, 32'hABC);
        check(sw_code == 12'h000, "R5 ignored", {20'b0, sw_code}, 32'h0);
        rd(A_LCK, x);  check(x == 32'h1, "R5 error set", x, 32'h1);
        rd(A_LCK, x);  check(x == 32'h0, "R5 error cleared", x, 32'h0);

        // R4: key then idle cycles then switch write accepted; one-shot
        wr(A_LCK, 32'hAA); idle(3); wr(A_SW, 32'h604);
        check(sw_code == 12'h604, "R4 accepted", {20'b0, sw_code}, 32'h604);
        wr(A_SW, 32'h608);
        check(sw_code == 12'h604, "R4 one-shot", {20'b0, sw_code}, 32'h604);
        rd(A_LCK, x);

        // R6: intervening read disarms
        wr(A_LCK, 32'hAA); rd(A_DIV, x); wr(A_SW, 32'h111);
        check(sw_code == 12'h604, "R6 read between", {20'b0, sw_code}, 32'h604);
        rd(A_LCK, x);  check(x == 32'h1, "R6 error", x, 32'h1);
        // R6: wrong lock value disarms
        wr(A_LCK, 32'hAA); wr(A_LCK, 32'hAB); wr(A_SW, 32'h222);
        check(sw_code == 12'h604, "R6 wrong key", {20'b0, sw_code}, 32'h604);
        // R6: repeated key re-arms
        wr(A_LCK, 32'hAA); wr(A_LCK, 32'hAA); wr(A_SW, 32'h602);
        check(sw_code == 12'h602, "R6 rearm", {20'b0, sw_code}, 32'h602);
        rd(A_LCK, x);

        // Table: settling per divisor (R8, R9), result format (R3), switch (R4)
        for (int i = 0; i < 6; i++) begin
            logic        fast;
            logic [11:0] code;
            logic [15:0] smp;
            int          exp_set;
            {fast, code, smp} = VEC[i];
            exp_set = fast ? SET_F : SET_S;
            idle(100);
            wr(A_DIV, {31'b0, fast});
            wr(A_LCK, 32'hAA);
            wr(A_SW, {20'b0, code});
            s = wr_edge;
            conv_data = smp;
            n = rise_cnt;
            rd(A_RES, x);
            wait_rises(n + 1);
            check(last_rise - s == exp_set, "R8 R9 settle cycles", last_rise - s, exp_set);
            check(sw_code == code, "R4 table switch", {20'b0, sw_code}, {20'b0, code});
            idle(3);
            rd(A_RES, x);
            check(x == {1'b1, 15'b0, smp}, "R3 result word", x, {1'b1, 15'b0, smp});
        end

        // R7, R10, R2: fast spacing, discard of in-flight conversion
        idle(100);
        wr(A_DIV, 32'h1);
        idle(100);
        conv_data = 16'h0AAA;
        n = rise_cnt;
        rd(A_RES, x);
        rd(A_RES, x);
        idle(2);
        rd(A_RES, x);
        check(x[31] == 1'b0, "R10 discarded", x, {1'b0, x[30:0]});
        conv_data = 16'h0BBB;
        wait_rises(n + 2);
        check(last_rise - prev_rise == CONV_F, "R7 fast spacing", last_rise - prev_rise, CONV_F);
        idle(3);
        rd(A_RES, x);
        check(x == 32'h8000_0BBB, "R10 later result", x, 32'h8000_0BBB);
        rd(A_RES, x);
        check(x[31] == 1'b0, "R2 ready cleared", x, {1'b0, x[30:0]});

        // R7, R9: slow spacing
        idle(100);
        wr(A_DIV, 32'h0);
        idle(100);
        n = rise_cnt;
        rd(A_RES, x);
        rd(A_RES, x);
        wait_rises(n + 2);
        check(last_rise - prev_rise == CONV_S, "R7 R9 slow spacing", last_rise - prev_rise, CONV_S);

        // R11: request held without acknowledge
        idle(100);
        hold = 1'b1;
        conv_data = 16'h1357;
        n = rise_cnt;
        rd(A_RES, x);
        wait_rises(n + 1);
        idle(25);
        check(conv_req == 1'b1, "R11 request held", {31'b0, conv_req}, 32'h1);
        hold = 1'b0;
        idle(5);
        rd(A_RES, x);
        check(x == 32'h8000_1357, "R11 captured on ack", x, 32'h8000_1357);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule